// File: doc/BRIEF.md
# PWM Period Timer with Sync Input and Sync Output

The block is the period timer of a pulse-width modulator. It counts clock cycles from zero up to a programmed terminal value, returns to zero and repeats, so one PWM cycle lasts (terminal value + 1) clocks. Each return to zero is flagged by a one-cycle rollover strobe that downstream compare logic uses to start its next cycle.

Several controllers in one power system can be locked together. On the receive side, one of eight candidate lines is chosen by a select field and passed through a two-stage synchronizer. When receiving is enabled, the active edge of that line restarts the counter. The programmed terminal value stays in force as a fallback: if no edge arrives, the counter keeps rolling over at its own period. On the transmit side, each rollover can launch a fixed-width pulse for other controllers to lock onto. A single polarity input chooses both the active input edge and the active output level.

The programmed period should be set a little longer than the expected external period. Then the external edges set the rhythm, and the local period only takes over when edges go missing.

Top module: `pwm_sync_timebase`

## Requirements
- R1: While `rst` is high, `count_o` is 0, `rollover_o` is 0 and `sync_out` sits at its inactive level (the inverse of `sync_pol`).
- R2: With no restart request, `count_o` rises by 1 per clock from 0 to `period_i` and returns to 0 on the next clock, giving a cycle of `period_i`+1 clocks. If `count_o` is already above a newly lowered `period_i`, it returns to 0 on the next clock.
- R3: `rollover_o` is 1 for exactly the cycles in which `count_o` has just been restarted to 0, whatever the cause, and 0 otherwise.
- R4: With `sync_in_en`=1, an active edge on the selected line restarts the counter. `count_o` reads 0 and `rollover_o` reads 1 after the third rising clock edge that follows the line change (two synchronizer stages plus one edge stage).
- R5: `sync_pol`=1 makes a rising input edge active and `sync_pol`=0 makes a falling input edge active. The opposite edge has no effect.
- R6: `sync_sel` picks line number `sync_sel` of `sync_lines` (bit index). Edges on every other line have no effect on `count_o`.
- R7: With `sync_in_en`=0, edges on the selected line have no effect on `count_o` or `rollover_o`.
- R8: An active edge whose restart falls in the same cycle as a natural rollover gives one restart and one rollover strobe. The next strobe then comes a full period later.
- R9: After the last sync edge, the counter continues to roll over every `period_i`+1 clocks.
- R10: With `sync_out_en`=1, each rollover strobe drives `sync_out` to its active level (equal to `sync_pol`) for PULSE_CYC clocks, starting in the cycle after the strobe. A new strobe during a pulse restarts the pulse width.
- R11: While `sync_out_en` is 0, `sync_out` holds its inactive level.
- R12: A line held at its active level after an edge does not cause any further restart. Each detected edge gives at most one restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| period_i | input | CNT_W | Terminal count of the PWM cycle |
| sync_in_en | input | 1 | Allows selected-line edges to restart the counter |
| sync_out_en | input | 1 | Allows rollover pulses on `sync_out` |
| sync_pol | input | 1 | 1: rising edge in, active-high out; 0: falling edge in, active-low out |
| sync_sel | input | SEL_W | Index of the candidate line used as sync input |
| sync_lines | input | SRC_N | Candidate asynchronous sync lines |
| count_o | output | CNT_W | Current counter value |
| rollover_o | output | 1 | One-cycle strobe when the counter restarts |
| sync_out | output | 1 | Sync pulse for other controllers |

## Verification
The free-running count is swept over every terminal value from 0 to 9, under both polarities and with the output pulse both enabled and disabled. This separates an off-by-one period from a correct one, and a stretched or shifted output pulse from a correct one, including the degenerate period of zero where strobes merge into a continuous pulse. Every line index is tried under both polarities. Active edges are applied first on all non-selected lines and then on the selected one, which separates a wrong select decode, a wrong edge sense and wrong synchronizer latency. Separate runs time an edge to land exactly on a natural rollover, hold the line after an edge, disable reception, and lower the period below the current count. These distinguish double restarts, level-triggered restarts and a lost fallback period.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  // Number of candidate sync lines and width of their selector
  localparam int unsigned SRC_N = 8;
  localparam int unsigned SEL_W = $clog2(SRC_N);

  typedef logic [SEL_W-1:0] src_sel_t;

  // Active edge test: pol=1 rising, pol=0 falling
  function automatic logic edge_hit(input logic pol, input logic now_v, input logic prev_v);
    return pol ? (now_v & ~prev_v) : (~now_v & prev_v);
  endfunction

  // Level seen on the output pin for an internal "active" flag
  function automatic logic drive_level(input logic pol, input logic active);
    return pol ? active : ~active;
  endfunction

endpackage

// File: rtl/sync_in_detect.sv
module sync_in_detect
  import pwm_sync_pkg::*;
#(
  parameter int unsigned LINES  = SRC_N,
  parameter int unsigned SW     = SEL_W,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    sel,
  input  logic [LINES-1:0] lines,
  input  logic             pol,
  output logic             edge_o
);

  logic picked;
  logic [STAGES:0] stage_q;   // [STAGES-1:0] synchronizer, [STAGES] edge history

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (SW'(i) == sel) picked = lines[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= picked;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign edge_o = edge_hit(pol, stage_q[STAGES-1], stage_q[STAGES]);

endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  input  logic             ext_restart,
  output logic [CNT_W-1:0] count_o,
  output logic             roll_o
);

  logic [CNT_W-1:0] count_q;
  logic             roll_q;
  logic             at_end;
  logic             restart;

  assign at_end  = (count_q >= period_i);
  assign restart = at_end | ext_restart;   // one restart even if both coincide

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      roll_q  <= 1'b0;
    end else begin
      roll_q  <= restart;
      if (restart) count_q <= '0;
      else         count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;
  assign roll_o  = roll_q;

endmodule

// File: rtl/sync_out_pulse.sv
module sync_out_pulse
  import pwm_sync_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pol,
  input  logic start,
  output logic pin_o
);

  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] left_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      act_q  <= 1'b0;
    end else begin
      act_q <= en & (start | (left_q > PW'(1)));
      if (!en)                 left_q <= '0;
      else if (start)          left_q <= PW'(PULSE_CYC);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
    end
  end

  assign pin_o = drive_level(pol, act_q);

endmodule

// File: rtl/pwm_sync_timebase.sv
module pwm_sync_timebase
  import pwm_sync_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PULSE_CYC = 25,
  parameter int unsigned LINES     = SRC_N,
  parameter int unsigned SW        = SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  input  logic             sync_in_en,
  input  logic             sync_out_en,
  input  logic             sync_pol,
  input  logic [SW-1:0]    sync_sel,
  input  logic [LINES-1:0] sync_lines,
  output logic [CNT_W-1:0] count_o,
  output logic             rollover_o,
  output logic             sync_out
);

  logic edge_seen;
  logic ext_hit;

  sync_in_detect #(
    .LINES (LINES),
    .SW    (SW),
    .STAGES(2)
  ) u_detect (
    .clk   (clk),
    .rst   (rst),
    .sel   (sync_sel),
    .lines (sync_lines),
    .pol   (sync_pol),
    .edge_o(edge_seen)
  );

  assign ext_hit = sync_in_en & edge_seen;

  period_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk        (clk),
    .rst        (rst),
    .period_i   (period_i),
    .ext_restart(ext_hit),
    .count_o    (count_o),
    .roll_o     (rollover_o)
  );

  sync_out_pulse #(
    .PULSE_CYC(PULSE_CYC)
  ) u_pulse (
    .clk  (clk),
    .rst  (rst),
    .en   (sync_out_en),
    .pol  (sync_pol),
    .start(rollover_o),
    .pin_o(sync_out)
  );

endmodule

// File: rtl/pwm_sync_timebase_chk.sv
module pwm_sync_timebase_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] period_i,
  input logic             sync_out_en,
  input logic             sync_pol,
  input logic             ext_hit,
  input logic [CNT_W-1:0] count_o,
  input logic             rollover_o,
  input logic             sync_out
);

  // R3
  strobe_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rollover_o |-> (count_o == '0));

  // R2
  end_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    (count_o >= period_i) |=> rollover_o);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((count_o < period_i) && !ext_hit) |=> (count_o == CNT_W'($past(count_o) + 1'b1)) && !rollover_o);

  // R4
  ext_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ext_hit |=> (rollover_o && count_o == '0));

  // R10
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    (rollover_o && sync_out_en) |=> (sync_out == sync_pol));

  // R11
  out_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sync_out_en) |-> (sync_out == ~sync_pol));

endmodule

bind pwm_sync_timebase pwm_sync_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .period_i   (period_i),
  .sync_out_en(sync_out_en),
  .sync_pol   (sync_pol),
  .ext_hit    (ext_hit),
  .count_o    (count_o),
  .rollover_o (rollover_o),
  .sync_out   (sync_out)
);

// File: tb/pwm_sync_timebase_bench.sv
module pwm_sync_timebase_bench;

  localparam int CW = 8;
  localparam int PC = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] period_i = '0;
  logic          sync_in_en = 1'b0;
  logic          sync_out_en = 1'b0;
  logic          sync_pol = 1'b1;
  logic [2:0]    sync_sel = '0;
  logic [7:0]    sync_lines = '0;
  logic [CW-1:0] count_o;
  logic          rollover_o;
  logic          sync_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  pwm_sync_timebase #(.CNT_W(CW), .PULSE_CYC(PC)) u_pwm_sync_timebase (
    .clk(clk), .rst(rst), .period_i(period_i), .sync_in_en(sync_in_en),
    .sync_out_en(sync_out_en), .sync_pol(sync_pol), .sync_sel(sync_sel),
    .sync_lines(sync_lines), .count_o(count_o), .rollover_o(rollover_o),
    .sync_out(sync_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_cnt(input string tag, input int exp_c, input int exp_r);
    chk(int'(count_o) == exp_c, tag, int'(count_o), exp_c);
    chk(int'(rollover_o) == exp_r, tag, int'(rollover_o), exp_r);
  endtask

  function automatic bit pulse_due(input int k, input int p);
    for (int j = k - PC; j <= k - 1; j++)
      if (j >= 1 && (j % (p + 1)) == 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    // R1 reset state
    chk_cnt("R1", 0, 0);
    chk(sync_out == ~sync_pol, "R1", int'(sync_out), int'(~sync_pol));
    rst = 1'b0;
  endtask

  initial begin
    // Free-running sweep: R2, R3, R10, R11
    for (int pol = 0; pol < 2; pol++) begin
      for (int oe = 0; oe < 2; oe++) begin
        for (int p = 0; p < 10; p++) begin
          sync_pol = pol[0]; sync_out_en = oe[0]; sync_in_en = 1'b0;
          period_i = CW'(p); sync_lines = '0;
          do_reset();
          for (int k = 1; k <= 3 * (p + 1) + 4; k++) begin
            logic exp_o;
            step();
            chk_cnt((k % (p + 1) == 0) ? "R3" : "R2", k % (p + 1), (k % (p + 1) == 0) ? 1 : 0);
            exp_o = (oe != 0 && pulse_due(k, p)) ? pol[0] : ~pol[0];
            chk(sync_out == exp_o, (oe != 0) ? "R10" : "R11", int'(sync_out), int'(exp_o));
          end
        end
      end
    end

    // Edge restart per line and polarity: R4, R5, R6, R12
    for (int pol = 0; pol < 2; pol++) begin
      for (int s = 0; s < 8; s++) begin
        sync_pol = pol[0]; sync_in_en = 1'b1; sync_out_en = 1'b0;
        period_i = CW'(40); sync_sel = 3'(s);
        sync_lines = (pol != 0) ? 8'h00 : 8'hFF;
        do_reset();
        for (int k = 1; k <= 20; k++) begin
          step();
          if (k < 13)       chk_cnt((k <= 10) ? "R6" : "R4", k, 0);
          else if (k == 13) chk_cnt((pol != 0) ? "R4" : "R5", 0, 1);
          else              chk_cnt("R12", k - 13, 0);
          if (k == 5)  sync_lines = (pol != 0) ? (~(8'h01 << s)) : (8'h01 << s);
          if (k == 10) sync_lines = (pol != 0) ? 8'hFF : 8'h00;
        end
      end
    end

    // Reception disabled: R7
    sync_pol = 1'b1; sync_in_en = 1'b0; period_i = CW'(40);
    sync_sel = 3'd2; sync_lines = 8'h00;
    do_reset();
    for (int k = 1; k <= 12; k++) begin
      step();
      chk_cnt("R7", k, 0);
      if (k == 3) sync_lines = 8'hFF;
    end

    // Edge landing on natural rollover, then fallback period: R8, R9
    sync_pol = 1'b1; sync_in_en = 1'b1; period_i = CW'(20);
    sync_sel = 3'd0; sync_lines = 8'h00;
    do_reset();
    for (int k = 1; k <= 45; k++) begin
      step();
      chk_cnt((k >= 19 && k <= 23) ? "R8" : "R9", k % 21, (k % 21 == 0) ? 1 : 0);
      if (k == 18) sync_lines = 8'h01;
    end

    // Period lowered below current count: R2
    sync_in_en = 1'b0; period_i = CW'(30); sync_lines = 8'h00;
    do_reset();
    for (int k = 1; k <= 33; k++) begin
      step();
      if (k <= 20)      chk_cnt("R2", k, 0);
      else if (k == 21) chk_cnt("R2", 0, 1);
      else              chk_cnt("R2", (k - 21) % 11, ((k - 21) % 11 == 0) ? 1 : 0);
      if (k == 20) period_i = CW'(10);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule